// File: doc/BRIEF.md
# Transfer Unit Size Searcher

This block picks the transfer-unit (TU) size for a DisplayPort main link, and the way the average number of valid symbols per TU is encoded. From the pixel clock, the bits per pixel, the lane count and the link rate, it forms the packed data rate carried by each lane. It then scales the ratio of that rate to the link symbol rate by 100000, which is one symbol. It tries each TU size from 64 down to 32. For each size it encodes the valid-symbol count as an integer part plus a reciprocal fraction 1/divisor, with the divisor at most 15. A direction flag tells whether the fraction is added to the integer part or is the "one symbol minus a fraction" form. The block keeps the encoding with the smallest approximation error.

The datapath is fully sequential. A single restoring divider, shared by every division, is driven by a state machine. A search begins on a `start` pulse taken while the block is idle. It ends with a one-cycle `done` pulse, after which the result outputs hold steady until the next search completes. Writing the result into link configuration registers is left to the surrounding logic.

Top module: `tus_search`

## Requirements
- R1: After reset, `done`, `fail`, `tu_size`, `vtu_int`, `vtu_frac` and `vtu_add` are all zero.
- R2: The per-lane rate is floor(floor(pix_clk*bpp/8)/lanes). `lane_code` 0 means one lane, 1 means two lanes, and 2 or 3 mean four lanes. `link_sel` 0 selects 162000 and 1 selects 270000.
- R3: The ratio is floor(rate*100000/link), kept to 32 bits. For each TU the valid count is (ratio*TU) mod 2^32. The integer part is that count divided by 100000 (floor), and the remainder is what is left over.
- R4: TU sizes are tried from 64 down to 32. A candidate replaces the held best only when its error is strictly smaller, so on a tie the larger TU is kept. The error starts from a bound of 64 symbols.
- R5: A zero remainder gives integer part minus one, divisor 1 and flag 0, with error 0.
- R6: A remainder of at least 50000 gives divisor f = ceil(100000/(100000-rem)). If f ≤ 15, the flag is 1 and the error is 100000 - floor(100000/f) - rem. Otherwise the flag is 0, the divisor is 1 and the error is 100000 - rem.
- R7: A nonzero remainder below 50000 gives divisor f = min(floor(100000/rem), 15), flag 0, and error floor(100000/f) - rem.
- R8: A candidate with error exactly 0 ends the search at once.
- R9: A candidate whose integer part would go below zero is rejected. If no candidate is accepted, `fail` is 1 and `tu_size`, `vtu_int`, `vtu_frac` and `vtu_add` are 0.
- R10: `done` is high for exactly one cycle per search. The result outputs change only in the cycle that `done` is high.
- R11: A `start` pulse during a search is ignored. Inputs are sampled only on the `start` that begins a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (taken when idle) |
| pix_clk | input | CLK_W | Pixel clock in kHz |
| bpp | input | BPP_W | Bits per pixel |
| lane_code | input | 2 | Lane count code (0:1, 1:2, else 4) |
| link_sel | input | 1 | Link rate (0:162000, 1:270000) |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No acceptable candidate found |
| tu_size | output | 7 | Chosen TU size |
| vtu_int | output | 32 | Integer part of valid symbols per TU |
| vtu_frac | output | 4 | Reciprocal fraction divisor |
| vtu_add | output | 1 | Fraction direction flag |

## Verification
The main sweep crosses several common pixel clocks and bit depths with every lane code and both link rates. Across these runs the winning candidates land in different remainder branches, and the chosen TU moves around with the ratio. An exact-ratio stimulus separates the zero-remainder encoding and the early stop from a full search; the early stop is observed through the completion latency. A zero pixel clock drives every candidate into integer-part underflow, which separates the failure path. Lane code 3 checks the four-lane alias. A second start issued mid-search, with changed inputs, shows that only the first request is honoured.

// File: rtl/tus_pkg.sv
package tus_pkg;

    localparam int SYM     = 100000;
    localparam int SYM_W   = 17;
    localparam int VAL_W   = 32;
    localparam int ERR_W   = 24;
    localparam int TU_W    = 7;
    localparam int FR_W    = 4;
    localparam int DVS_W   = 19;
    localparam int TU_TOP  = 64;
    localparam int TU_BOT  = 32;
    localparam int FR_MAX  = 15;
    localparam int LINK_LO = 162000;
    localparam int LINK_HI = 270000;

    typedef struct packed {
        logic [TU_W-1:0]  tu;
        logic [VAL_W-1:0] vint;
        logic [FR_W-1:0]  frac;
        logic             add;
        logic [ERR_W-1:0] err;
    } tus_cand_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RATIO, ST_MUL, ST_LAUNCH, ST_INT, ST_SPLIT,
        ST_CEIL, ST_FLOOR, ST_RECIP_ADD, ST_RECIP_SUB, ST_EVAL, ST_FINISH
    } tus_state_e;

    function automatic logic [1:0] lane_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [DVS_W-1:0] link_rate(input logic sel);
        return sel ? DVS_W'(LINK_HI) : DVS_W'(LINK_LO);
    endfunction

endpackage

// File: rtl/tus_divider.sv
module tus_divider #(
    parameter int DIV_W   = 40,
    parameter int DVS_W   = 19,
    parameter int SHORT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             short_op,
    input  logic [DIV_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             fin,
    output logic [DIV_W-1:0] quo,
    output logic [DVS_W-1:0] rem
);
    localparam int CNT_W = $clog2(DIV_W + 1);

    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DVS_W-1:0] d_q;
    logic [DVS_W:0]   r_sh;
    logic [DVS_W:0]   r_sub;
    logic             ge;

    always_comb begin
        r_sh  = {rem, quo[DIV_W-1]};
        r_sub = r_sh - {1'b0, d_q};
        ge    = r_sh >= {1'b0, d_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo  <= '0;
            rem  <= '0;
            d_q  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                quo  <= short_op ? (dividend << (DIV_W - SHORT_W)) : dividend;
                rem  <= '0;
                d_q  <= divisor;
                cnt  <= short_op ? CNT_W'(SHORT_W) : CNT_W'(DIV_W);
                busy <= 1'b1;
            end else if (busy) begin
                rem <= ge ? r_sub[DVS_W-1:0] : r_sh[DVS_W-1:0];
                quo <= {quo[DIV_W-2:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> (rem < d_q));

    // R3
    fin_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> !busy);

endmodule

// File: rtl/tus_best_keeper.sv
module tus_best_keeper
    import tus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  tus_cand_t        cand,
    output logic             better,
    output logic             found,
    output logic [TU_W-1:0]  best_tu,
    output logic [VAL_W-1:0] best_vint,
    output logic [FR_W-1:0]  best_frac,
    output logic             best_add
);
    logic [ERR_W-1:0] best_err;

    assign better = upd && (cand.err < best_err);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best_tu   <= '0;
            best_vint <= '0;
            best_frac <= '0;
            best_add  <= 1'b0;
            best_err  <= ERR_W'(TU_TOP * SYM);
            found     <= 1'b0;
        end else if (better) begin
            best_tu   <= cand.tu;
            best_vint <= cand.vint;
            best_frac <= cand.frac;
            best_add  <= cand.add;
            best_err  <= cand.err;
            found     <= 1'b1;
        end
    end

    // R4
    err_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (best_err <= $past(best_err)));

endmodule

// File: rtl/tus_search.sv
module tus_search
    import tus_pkg::*;
#(
    parameter int CLK_W = 20,
    parameter int BPP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CLK_W-1:0] pix_clk,
    input  logic [BPP_W-1:0] bpp,
    input  logic [1:0]       lane_code,
    input  logic             link_sel,
    output logic             done,
    output logic             fail,
    output logic [TU_W-1:0]  tu_size,
    output logic [VAL_W-1:0] vtu_int,
    output logic [FR_W-1:0]  vtu_frac,
    output logic             vtu_add
);
    localparam int PROD_W = CLK_W + BPP_W;
    localparam int DIV_W  = PROD_W - 3 + SYM_W;
    localparam logic [SYM_W-1:0] SYM_V  = SYM_W'(SYM);
    localparam logic [SYM_W-1:0] HALF_V = SYM_W'(SYM / 2);

    tus_state_e       st;
    logic [VAL_W-1:0] ratio_q, tv_q, vint_q;
    logic [SYM_W-1:0] rmd_q;
    logic [TU_W-1:0]  tu_q;
    logic [FR_W-1:0]  frac_q;
    logic             add_q, ok_q;
    logic [ERR_W-1:0] err_q;

    logic             div_go, div_short, div_fin;
    logic [DIV_W-1:0] div_a, div_quo;
    logic [DVS_W-1:0] div_b, div_rem;

    logic [PROD_W-1:0] prod, lane_rate;
    logic [DIV_W-1:0]  ratio_num;
    logic [SYM_W:0]    f_ceil;
    logic              ceil_fits;
    logic [FR_W-1:0]   f_floor;
    logic [ERR_W-1:0]  err_add, err_sub, err_none;

    tus_cand_t        cand;
    logic             keep_clr, keep_upd, keep_better, keep_found;
    logic [TU_W-1:0]  best_tu;
    logic [VAL_W-1:0] best_vint;
    logic [FR_W-1:0]  best_frac;
    logic             best_add;

    always_comb begin
        prod      = PROD_W'(pix_clk) * PROD_W'(bpp);
        lane_rate = (prod >> 3) >> lane_shift(lane_code);
        ratio_num = DIV_W'(lane_rate) * DIV_W'(SYM);
        f_ceil    = {1'b0, div_quo[SYM_W-1:0]} + {{SYM_W{1'b0}}, (div_rem != '0)};
        ceil_fits = f_ceil <= (SYM_W+1)'(FR_MAX);
        f_floor   = (div_quo > DIV_W'(FR_MAX)) ? FR_W'(FR_MAX) : div_quo[FR_W-1:0];
        err_add   = ERR_W'(SYM) - ERR_W'(div_quo[SYM_W-1:0]) - ERR_W'(rmd_q);
        err_sub   = ERR_W'(div_quo[SYM_W-1:0]) - ERR_W'(rmd_q);
        err_none  = ERR_W'(SYM) - ERR_W'(rmd_q);
        cand      = '{tu: tu_q, vint: vint_q, frac: frac_q, add: add_q, err: err_q};
        keep_clr  = (st == ST_IDLE) && start;
        keep_upd  = (st == ST_EVAL) && ok_q;
    end

    tus_divider #(.DIV_W(DIV_W), .DVS_W(DVS_W), .SHORT_W(SYM_W)) i_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .short_op (div_short),
        .dividend (div_a),
        .divisor  (div_b),
        .fin      (div_fin),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    tus_best_keeper i_keep (
        .clk       (clk),
        .rst       (rst),
        .clr       (keep_clr),
        .upd       (keep_upd),
        .cand      (cand),
        .better    (keep_better),
        .found     (keep_found),
        .best_tu   (best_tu),
        .best_vint (best_vint),
        .best_frac (best_frac),
        .best_add  (best_add)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ratio_q   <= '0;
            tv_q      <= '0;
            vint_q    <= '0;
            rmd_q     <= '0;
            tu_q      <= '0;
            frac_q    <= '0;
            add_q     <= 1'b0;
            ok_q      <= 1'b0;
            err_q     <= '0;
            div_go    <= 1'b0;
            div_short <= 1'b0;
            div_a     <= '0;
            div_b     <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            tu_size   <= '0;
            vtu_int   <= '0;
            vtu_frac  <= '0;
            vtu_add   <= 1'b0;
        end else begin
            done   <= 1'b0;
            div_go <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    div_go    <= 1'b1;
                    div_short <= 1'b0;
                    div_a     <= ratio_num;
                    div_b     <= link_rate(link_sel);
                    st        <= ST_RATIO;
                end
                ST_RATIO: if (div_fin) begin
                    ratio_q <= div_quo[VAL_W-1:0];
                    tu_q    <= TU_W'(TU_TOP);
                    st      <= ST_MUL;
                end
                ST_MUL: begin
                    tv_q <= ratio_q * {{(VAL_W-TU_W){1'b0}}, tu_q};
                    st   <= ST_LAUNCH;
                end
                ST_LAUNCH: begin
                    div_go    <= 1'b1;
                    div_short <= 1'b0;
                    div_a     <= DIV_W'(tv_q);
                    div_b     <= DVS_W'(SYM);
                    st        <= ST_INT;
                end
                ST_INT: if (div_fin) begin
                    vint_q <= div_quo[VAL_W-1:0];
                    rmd_q  <= div_rem[SYM_W-1:0];
                    st     <= ST_SPLIT;
                end
                ST_SPLIT: begin
                    ok_q <= 1'b1;
                    if (rmd_q == '0) begin
                        ok_q   <= (vint_q != '0);
                        vint_q <= vint_q - 1'b1;
                        frac_q <= FR_W'(1);
                        add_q  <= 1'b0;
                        err_q  <= '0;
                        st     <= ST_EVAL;
                    end else begin
                        div_go    <= 1'b1;
                        div_short <= 1'b1;
                        div_a     <= DIV_W'(SYM);
                        if (rmd_q >= HALF_V) begin
                            div_b <= DVS_W'(SYM_V - rmd_q);
                            st    <= ST_CEIL;
                        end else begin
                            div_b <= DVS_W'(rmd_q);
                            st    <= ST_FLOOR;
                        end
                    end
                end
                ST_CEIL: if (div_fin) begin
                    if (ceil_fits) begin
                        frac_q    <= f_ceil[FR_W-1:0];
                        add_q     <= 1'b1;
                        div_go    <= 1'b1;
                        div_short <= 1'b1;
                        div_a     <= DIV_W'(SYM);
                        div_b     <= DVS_W'(f_ceil);
                        st        <= ST_RECIP_ADD;
                    end else begin
                        frac_q <= FR_W'(1);
                        add_q  <= 1'b0;
                        err_q  <= err_none;
                        st     <= ST_EVAL;
                    end
                end
                ST_FLOOR: if (div_fin) begin
                    frac_q    <= f_floor;
                    add_q     <= 1'b0;
                    div_go    <= 1'b1;
                    div_short <= 1'b1;
                    div_a     <= DIV_W'(SYM);
                    div_b     <= DVS_W'(f_floor);
                    st        <= ST_RECIP_SUB;
                end
                ST_RECIP_ADD: if (div_fin) begin
                    err_q <= err_add;
                    st    <= ST_EVAL;
                end
                ST_RECIP_SUB: if (div_fin) begin
                    err_q <= err_sub;
                    st    <= ST_EVAL;
                end
                ST_EVAL: begin
                    if ((keep_better && err_q == '0) || tu_q == TU_W'(TU_BOT)) begin
                        st <= ST_FINISH;
                    end else begin
                        tu_q <= tu_q - 1'b1;
                        st   <= ST_MUL;
                    end
                end
                ST_FINISH: begin
                    done     <= 1'b1;
                    fail     <= !keep_found;
                    tu_size  <= best_tu;
                    vtu_int  <= best_vint;
                    vtu_frac <= best_frac;
                    vtu_add  <= best_add;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({fail, tu_size, vtu_int, vtu_frac, vtu_add}) |-> done);

    // R4
    tu_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> (tu_size >= TU_W'(TU_BOT) && tu_size <= TU_W'(TU_TOP)));

    // R7
    frac_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> (vtu_frac >= FR_W'(1) && vtu_frac <= FR_W'(FR_MAX)));

    // R6
    add_frac_chk: assert property (@(posedge clk) disable iff (rst)
        (done && vtu_add) |-> (vtu_frac >= FR_W'(2)));

    // R9
    fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (tu_size == '0 && vtu_int == '0 && vtu_frac == '0 && !vtu_add));

    // R8
    early_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EVAL && ok_q && err_q == '0) |=> (st == ST_FINISH));

endmodule

// File: tb/test_tus_search.sv
module test_tus_search;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam longint SYMB   = 100000;
    localparam longint MASK32 = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] pix_clk = '0;
    logic [5:0]  bpp = '0;
    logic [1:0]  lane_code = '0;
    logic        link_sel = 1'b0;
    logic        done, fail, vtu_add;
    logic [6:0]  tu_size;
    logic [31:0] vtu_int;
    logic [3:0]  vtu_frac;

    int n_chk = 0;
    int n_err = 0;
    int lat   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tus_search i_tus_search (
        .clk(clk), .rst(rst), .start(start), .pix_clk(pix_clk), .bpp(bpp),
        .lane_code(lane_code), .link_sel(link_sel), .done(done), .fail(fail),
        .tu_size(tu_size), .vtu_int(vtu_int), .vtu_frac(vtu_frac), .vtu_add(vtu_add)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void ref_model(input longint ck, input longint bp, input int lc, input int ls,
                                      output int e_tu, output longint e_vi, output int e_f,
                                      output int e_a, output int e_fail);
        longint lanes, lb, rate, ratio, best, tv, vi, d, f, e;
        int a;
        bit ok;
        lanes = (lc == 0) ? 1 : (lc == 1) ? 2 : 4;
        lb    = ls ? 270000 : 162000;
        rate  = ((ck * bp) / 8) / lanes;
        ratio = ((rate * SYMB) / lb) & MASK32;
        best  = 64 * SYMB;
        e_tu = 0; e_vi = 0; e_f = 0; e_a = 0; e_fail = 1;
        for (int t = 64; t >= 32; t--) begin
            tv = (ratio * t) & MASK32;
            vi = tv / SYMB;
            d  = tv % SYMB;
            ok = 1'b1;
            if (d == 0) begin
                if (vi == 0) ok = 1'b0;
                vi = vi - 1; f = 1; a = 0; e = 0;
            end else if (d >= SYMB / 2) begin
                f = SYMB / (SYMB - d) + (((SYMB % (SYMB - d)) != 0) ? 1 : 0);
                if (f <= 15) begin a = 1; e = SYMB - SYMB / f - d; end
                else begin a = 0; f = 1; e = SYMB - d; end
            end else begin
                f = SYMB / d;
                if (f > 15) f = 15;
                a = 0; e = SYMB / f - d;
            end
            if (ok && e < best) begin
                best = e; e_tu = t; e_vi = vi & MASK32; e_f = int'(f); e_a = a; e_fail = 0;
                if (e == 0) break;
            end
        end
    endfunction

    task automatic launch(input int ck, input int bp, input int lc, input int ls);
        @(negedge clk);
        pix_clk = 20'(ck); bpp = 6'(bp); lane_code = 2'(lc); link_sel = 1'(ls);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
    endtask

    task automatic wait_done();
        while (!done && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic compare(input int ck, input int bp, input int lc, input int ls, input string tag);
        int e_tu, e_f, e_a, e_fail;
        longint e_vi;
        ref_model(ck, bp, lc, ls, e_tu, e_vi, e_f, e_a, e_fail);
        check(done == 1'b1, {tag, " R10 done seen"}, done, 1);
        check(fail == 1'(e_fail), {tag, " R9 fail flag"}, fail, e_fail);
        check(tu_size == 7'(e_tu), {tag, " R4 tu_size"}, tu_size, e_tu);
        check(vtu_int == 32'(e_vi), {tag, " R3 R5 vtu_int"}, vtu_int, e_vi);
        check(vtu_frac == 4'(e_f), {tag, " R6 R7 vtu_frac"}, vtu_frac, e_f);
        check(vtu_add == 1'(e_a), {tag, " R6 vtu_add"}, vtu_add, e_a);
        @(negedge clk);
        check(done == 1'b0, {tag, " R10 pulse width"}, done, 0);
        check(tu_size == 7'(e_tu), {tag, " R10 hold"}, tu_size, e_tu);
    endtask

    task automatic run_case(input int ck, input int bp, input int lc, input int ls, input string tag);
        launch(ck, bp, lc, ls);
        wait_done();
        compare(ck, bp, lc, ls, tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int clks[4];
        int bpps[4];
        clks = '{25175, 74250, 148500, 297000};
        bpps = '{24, 18, 30, 24};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done", done, 0);
        check(fail == 1'b0, "R1 fail", fail, 0);
        check(tu_size == '0, "R1 tu_size", tu_size, 0);
        check(vtu_int == '0, "R1 vtu_int", vtu_int, 0);
        check(vtu_frac == '0 && vtu_add == 1'b0, "R1 frac/add", {vtu_frac, vtu_add}, 0);

        // R2 R3 R4 R6 R7 sweep over clocks, lanes and link rates
        for (int ci = 0; ci < 4; ci++)
            for (int lc = 0; lc < 3; lc++)
                for (int ls = 0; ls < 2; ls++)
                    run_case(clks[ci], bpps[ci], lc, ls, "R2 sweep");

        // R2 lane code 3 aliases four lanes
        run_case(148500, 24, 3, 1, "R2 lane code 3");

        // R5 R8 exact ratio: 3375 kHz, 24 bpp, 1 lane, 162000 -> ratio 6250, TU 64 exact
        launch(3375, 24, 0, 0);
        wait_done();
        check(lat < 200, "R8 early stop latency", lat, 200);
        check(tu_size == 7'd64, "R5 exact tu", tu_size, 64);
        check(vtu_int == 32'd3, "R5 decremented int", vtu_int, 3);
        check(vtu_frac == 4'd1 && vtu_add == 1'b0, "R5 frac 1 flag 0", {vtu_frac, vtu_add}, 2);
        @(negedge clk);

        // R9 zero clock: every candidate underflows
        run_case(0, 24, 0, 0, "R9 zero clock");

        // R11 second start during search is ignored, inputs sampled at first start
        launch(74250, 24, 1, 0);
        repeat (10) @(negedge clk);
        lat += 10;
        pix_clk = 20'd297000; bpp = 6'd30; lane_code = 2'd0; link_sel = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat++;
        wait_done();
        compare(74250, 24, 1, 0, "R11 mid-search start");
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            check(!seen, "R11 no second search", seen, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule